// File: doc/BRIEF.md
# Looping Memory Read Sequencer

This block sits in the memory user clock domain and replays a stored file from external memory again and again. The write path stores the file and reports its length in 1 KB blocks. It then signals that the store has finished by flipping a level on a toggle line. The sequencer sees that flip and starts issuing read requests to the memory read/write controller. Each request is one burst of 256 words of 32 bits. When the last stored block has been requested, the sequencer wraps back to block zero. It keeps looping until an address-clear pulse stops it.

Returned words are written into a dual-clock FIFO with Gray-coded pointers. On the transmit clock, the FIFO presents one word per cycle with a valid strobe whenever it holds data. A request goes out only when two conditions hold: every word of the previous burst has arrived, and the FIFO has room for a whole burst. This keeps the buffer from overflowing even when the transmit side drains more slowly than memory fills it.

Top module: `loop_rd_seq`

## Requirements
- R1: After reset, `rdReq` and `txValid` are low and no request is made until a store-done event.
- R2: A change of level on `doneTgl` is a store-done event. It starts the loop at block 0, using the `storeSize` value present when the event is seen.
- R3: Each read request is a single-cycle `rdReq` pulse. `rdAddr` carries the byte address `blockIndex * 1024`, which is aligned to the 1 KB burst. The request asks for 256 words of 32 bits.
- R4: After the request for block `storeSize-1`, the next request is for block 0 (byte address 0), and looping continues.
- R5: A store-done event seen while `storeSize` is 0 issues no request.
- R6: A new request is issued only after all 256 words of the previous request have arrived on `rdValid`.
- R7: A request is issued only when the FIFO has room for 256 words, so no returned word is dropped. With a transmit side slower than memory, every word still comes out exactly once and in order.
- R8: On the transmit clock, `txValid` is high with the next stored word whenever the FIFO is not empty, and low once it has drained.
- R9: An `addrClear` pulse stops the loop, resets the block index to 0 and returns to idle. No request follows it, and it wins over a store-done event seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory user clock |
| rst | input | 1 | Active-high reset, memory clock domain |
| doneTgl | input | 1 | Store-done toggle from the write side (any clock) |
| storeSize | input | 16 | Stored file length in 1 KB blocks |
| addrClear | input | 1 | Read-address clear pulse, already in `clk` domain |
| rdReq | output | 1 | One-cycle read request to the memory controller |
| rdAddr | output | 30 | Byte address of the requested burst |
| rdData | input | 32 | Read word from the memory controller |
| rdValid | input | 1 | Read word strobe |
| txClk | input | 1 | Transmit-side clock |
| txRst | input | 1 | Active-high reset, transmit domain |
| txData | output | 32 | Word presented to the transmitter |
| txValid | output | 1 | `txData` holds a word this cycle |

## Verification
The bench drives several file lengths and checks every request address against the expected block index. It checks the wrap after a one-block file, where every request must be address 0. A sequencer that is off by one in its compare would request an extra block or skip block 0. The transmit clock runs slower than the memory clock, so any request made without enough FIFO room shows up as a missing or repeated word in the checked stream. A clear that lands in the same cycle as a store-done event, and a zero-length file, must both leave the memory interface silent. A design that lets the start win or ignores the zero size would issue a request.

// File: rtl/loop_rd_pkg.sv
package loop_rd_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;   // latch size, rewind block index
    logic issue;   // fire one burst request
    logic clear;   // rewind block index, stop
  } seq_cmd_t;

  // Status from the datapath back to the control FSM
  typedef struct packed {
    logic burstIdle; // every word of the last burst has arrived
    logic canIssue;  // burstIdle and room for a whole burst
  } seq_stat_t;

endpackage

// File: rtl/loop_rd_tsync.sv
module loop_rd_tsync (
  input  logic clk,
  input  logic rst,
  input  logic tglIn,
  output logic evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tglIn;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign evt = s2 ^ s3;
endmodule

// File: rtl/loop_rd_afifo.sv
module loop_rd_afifo #(
  parameter int DW       = 32,
  parameter int AW       = 9,
  parameter int MIN_FREE = 256
) (
  input  logic          wClk,
  input  logic          wRst,
  input  logic          wEn,
  input  logic [DW-1:0] wData,
  output logic          roomOk,
  output logic          full,
  input  logic          rClk,
  input  logic          rRst,
  output logic [DW-1:0] rData,
  output logic          rValid
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] bin2gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic [AW:0] wBin, wGray, rGrayS1, rGrayS2, rBinW, used;

  always_ff @(posedge wClk or posedge wRst) begin
    if (wRst) begin
      wBin    <= '0;
      wGray   <= '0;
      rGrayS1 <= '0;
      rGrayS2 <= '0;
    end else begin
      rGrayS1 <= rGray;
      rGrayS2 <= rGrayS1;
      if (wEn && !full) begin
        wBin  <= wBin + 1'b1;
        wGray <= bin2gray(wBin + 1'b1);
      end
    end
  end

  always_ff @(posedge wClk) begin
    if (wEn && !full) mem[wBin[AW-1:0]] <= wData;
  end

  assign rBinW  = gray2bin(rGrayS2);
  assign used   = wBin - rBinW;
  assign full   = (used == (AW+1)'(DEPTH));
  assign roomOk = ({1'b0, used} + (AW+2)'(MIN_FREE)) <= (AW+2)'(DEPTH);

  // read side
  logic [AW:0] rBin, rGray, wGrayS1, wGrayS2;
  logic        empty;

  assign empty = (rGray == wGrayS2);

  always_ff @(posedge rClk or posedge rRst) begin
    if (rRst) begin
      rBin    <= '0;
      rGray   <= '0;
      wGrayS1 <= '0;
      wGrayS2 <= '0;
      rValid  <= 1'b0;
      rData   <= '0;
    end else begin
      wGrayS1 <= wGray;
      wGrayS2 <= wGrayS1;
      if (!empty) begin
        rData  <= mem[rBin[AW-1:0]];
        rValid <= 1'b1;
        rBin   <= rBin + 1'b1;
        rGray  <= bin2gray(rBin + 1'b1);
      end else begin
        rValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/loop_rd_ctrl.sv
module loop_rd_ctrl
  import loop_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      doneEvt,
  input  logic      sizeNonZero,
  input  logic      addrClear,
  input  seq_stat_t stat,
  output seq_cmd_t  cmd
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_t;

  seq_state_t state, nxt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    cmd = '0;
    nxt = state;
    if (addrClear) begin
      cmd.clear = 1'b1;
      nxt       = ST_IDLE;
    end else if (doneEvt) begin
      cmd.start = 1'b1;
      nxt       = sizeNonZero ? ST_ISSUE : ST_IDLE;
    end else begin
      case (state)
        ST_ISSUE: if (stat.canIssue) begin
          cmd.issue = 1'b1;
          nxt       = ST_WAIT;
        end
        ST_WAIT: if (stat.burstIdle) nxt = ST_ISSUE;
        default: nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loop_rd_dp.sv
module loop_rd_dp
  import loop_rd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 30,
  parameter int SIZE_W  = 16,
  parameter int BURST   = 256,
  parameter int FIFO_AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_cmd_t          cmd,
  output seq_stat_t         stat,
  input  logic [SIZE_W-1:0] storeSize,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdValid,
  output logic              fifoFull,
  input  logic              txClk,
  input  logic              txRst,
  output logic [DATA_W-1:0] txData,
  output logic              txValid
);
  localparam int BURST_BYTES = BURST * DATA_W / 8;
  localparam int SHIFT       = $clog2(BURST_BYTES);
  localparam int CNT_W       = $clog2(BURST + 1);

  logic [SIZE_W-1:0] sizeReg, blkIdx;
  logic [CNT_W-1:0]  wordsLeft;
  logic              roomOk;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sizeReg   <= '0;
      blkIdx    <= '0;
      wordsLeft <= '0;
      rdReq     <= 1'b0;
      rdAddr    <= '0;
    end else begin
      rdReq <= 1'b0;
      if (cmd.start) begin
        sizeReg <= storeSize;
        blkIdx  <= '0;
      end else if (cmd.clear) begin
        blkIdx <= '0;
      end else if (cmd.issue) begin
        rdReq  <= 1'b1;
        rdAddr <= ADDR_W'(blkIdx) << SHIFT;
        blkIdx <= (blkIdx == sizeReg - 1'b1) ? '0 : blkIdx + 1'b1;
      end
      if (cmd.issue)
        wordsLeft <= CNT_W'(BURST);
      else if (rdValid && wordsLeft != '0)
        wordsLeft <= wordsLeft - 1'b1;
    end
  end

  assign stat.burstIdle = (wordsLeft == '0);
  assign stat.canIssue  = stat.burstIdle && roomOk;

  loop_rd_afifo #(
    .DW       (DATA_W),
    .AW       (FIFO_AW),
    .MIN_FREE (BURST)
  ) fifo_i (
    .wClk   (clk),
    .wRst   (rst),
    .wEn    (rdValid),
    .wData  (rdData),
    .roomOk (roomOk),
    .full   (fifoFull),
    .rClk   (txClk),
    .rRst   (txRst),
    .rData  (txData),
    .rValid (txValid)
  );
endmodule

// File: rtl/loop_rd_seq.sv
module loop_rd_seq
  import loop_rd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 30,
  parameter int SIZE_W     = 16,
  parameter int BURST      = 256,
  parameter int FIFO_DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              doneTgl,
  input  logic [SIZE_W-1:0] storeSize,
  input  logic              addrClear,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdValid,
  input  logic              txClk,
  input  logic              txRst,
  output logic [DATA_W-1:0] txData,
  output logic              txValid
);
  localparam int FIFO_AW = $clog2(FIFO_DEPTH);

  logic      doneEvt;
  logic      fifoFull;
  seq_cmd_t  cmd;
  seq_stat_t stat;

  loop_rd_tsync done_sync_i (
    .clk   (clk),
    .rst   (rst),
    .tglIn (doneTgl),
    .evt   (doneEvt)
  );

  loop_rd_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .doneEvt     (doneEvt),
    .sizeNonZero (storeSize != '0),
    .addrClear   (addrClear),
    .stat        (stat),
    .cmd         (cmd)
  );

  loop_rd_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .BURST   (BURST),
    .FIFO_AW (FIFO_AW)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .stat      (stat),
    .storeSize (storeSize),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .fifoFull  (fifoFull),
    .txClk     (txClk),
    .txRst     (txRst),
    .txData    (txData),
    .txValid   (txValid)
  );
endmodule

// File: rtl/loop_rd_seq_chk.sv
module loop_rd_seq_chk #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int BURST  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              addrClear,
  input logic              fifoFull
);
  localparam int SHIFT = $clog2(BURST * DATA_W / 8);
  localparam int CNT_W = $clog2(BURST + 1);

  logic [CNT_W-1:0] pending;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pending <= '0;
    else if (rdReq) pending <= CNT_W'(BURST);
    else if (rdValid && pending != '0) pending <= pending - 1'b1;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rdReq |=> !rdReq); // R3
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    rdReq |-> (rdAddr[SHIFT-1:0] == '0)); // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    rdReq |-> (pending == '0)); // R6
  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (rst)
    addrClear |=> !rdReq); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> !fifoFull); // R7
endmodule

bind loop_rd_seq loop_rd_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BURST  (BURST)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rdReq     (rdReq),
  .rdAddr    (rdAddr),
  .rdValid   (rdValid),
  .addrClear (addrClear),
  .fifoFull  (fifoFull)
);

// File: tb/loop_rd_seq_tb_top.sv
`timescale 1ns / 1ps
module loop_rd_seq_tb_top;
  localparam int BURST = 256;
  localparam int NVEC  = 4;
  // stimulus: file size in blocks; words to check on tx; minimum requests expected
  localparam int VEC_SIZE [NVEC] = '{1, 3, 5, 2};
  localparam int VEC_WORDS[NVEC] = '{600, 1000, 1400, 700};
  localparam int VEC_REQS [NVEC] = '{3, 4, 6, 3};

  logic        clk = 1'b0, txClk = 1'b0;
  logic        rst, txRst, doneTgl, addrClear, rdValid;
  logic [15:0] storeSize;
  logic [31:0] rdData, txData;
  logic [29:0] rdAddr;
  logic        rdReq, txValid;

  int checks = 0, fails = 0;
  int reqIdx = 0, curSize = 1, monCnt = 0, quietReqs = 0, txSeen = 0;
  bit monOn = 0, quiet = 1;
  int respLeft = 0, respK = 0, respDelay = 0, respBase = 0;

  always #5 clk = ~clk;
  always #7.5 txClk = ~txClk;

  loop_rd_seq dut_i (
    .clk(clk), .rst(rst), .doneTgl(doneTgl), .storeSize(storeSize),
    .addrClear(addrClear), .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .txClk(txClk), .txRst(txRst), .txData(txData),
    .txValid(txValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory controller model
  initial begin
    rdValid = 1'b0;
    rdData  = '0;
    forever begin
      @(negedge clk);
      if (rdReq) begin
        if (quiet) quietReqs++;
        else begin
          check(respLeft == 0, "R6 request while burst outstanding", respLeft, 0);
          check(rdAddr == 30'((reqIdx % curSize) * BURST * 4), "R3/R4 request address",
                rdAddr, (reqIdx % curSize) * BURST * 4);
        end
        reqIdx++;
        respLeft  = BURST;
        respK     = 0;
        respBase  = int'(rdAddr >> 2);
        respDelay = 3;
      end
      if (respLeft != 0 && respDelay == 0) begin
        rdValid = 1'b1;
        rdData  = 32'(respBase + respK + 1);
        respK++;
        respLeft--;
      end else begin
        rdValid = 1'b0;
        if (respDelay != 0) respDelay--;
      end
    end
  end

  // transmit side monitor
  initial forever begin
    @(negedge txClk);
    if (txValid) begin
      txSeen++;
      if (monOn) begin
        int b, expW;
        b    = (monCnt / BURST) % curSize;
        expW = b * BURST + monCnt % BURST + 1;
        check(txData == 32'(expW), "R7/R8 tx word order", txData, expW);
        monCnt++;
      end
    end
  end

  task automatic pulseDone();
    @(negedge clk);
    doneTgl = ~doneTgl;
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishTest();
  end

  initial begin
    rst = 1'b1; txRst = 1'b1; doneTgl = 1'b0; addrClear = 1'b0; storeSize = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0; txRst = 1'b0;
    repeat (3) @(negedge clk);
    check(rdReq == 1'b0, "R1 rdReq after reset", rdReq, 0);
    check(txValid == 1'b0, "R1 txValid after reset", txValid, 0);
    repeat (50) @(negedge clk);
    check(quietReqs == 0, "R1 no request before store-done", quietReqs, 0);

    // zero-size file
    storeSize = 16'd0;
    pulseDone();
    repeat (400) @(negedge clk);
    check(quietReqs == 0, "R5 zero size issues nothing", quietReqs, 0);
    check(txSeen == 0, "R5 no tx words for zero size", txSeen, 0);

    // clear and store-done seen in the same cycle
    storeSize = 16'd3;
    pulseDone();
    @(posedge clk); @(posedge clk); @(negedge clk);
    addrClear = 1'b1;
    @(negedge clk);
    addrClear = 1'b0;
    repeat (300) @(negedge clk);
    check(quietReqs == 0, "R9 clear beats simultaneous start", quietReqs, 0);

    // table of file sizes
    for (int v = 0; v < NVEC; v++) begin
      int guard;
      curSize   = VEC_SIZE[v];
      storeSize = 16'(VEC_SIZE[v]);
      reqIdx = 0; monCnt = 0; quietReqs = 0;
      quiet = 0; monOn = 1;
      pulseDone();  // R2 start from block 0
      guard = 0;
      while (monCnt < VEC_WORDS[v] && guard < 30000) begin
        @(negedge clk);
        guard++;
      end
      monOn = 0;
      check(monCnt >= VEC_WORDS[v], "R2/R4 looped words delivered", monCnt, VEC_WORDS[v]);
      check(reqIdx >= VEC_REQS[v], "R4 requests across wrap", reqIdx, VEC_REQS[v]);
      addrClear = 1'b1;
      quiet = 1;
      @(negedge clk);
      addrClear = 1'b0;
      repeat (1500) @(negedge clk);
      check(quietReqs == 0, "R9 no request after clear", quietReqs, 0);
      @(negedge txClk);
      check(txValid == 1'b0, "R8 txValid low once drained", txValid, 0);
    end

    finishTest();
  end
endmodule